// File: doc/BRIEF.md
# Multiplexed Common-Bus Register Transfer Datapath

This block is a small datapath of five 16-bit registers that exchange data over one shared bus. A source multiplexer places exactly one register on the bus. A separate load vector then chooses which registers take that bus value on the next rising clock edge. Three of the registers are general-purpose (`gp1`, `gp2`, `gp3`). One holds an instruction word (`instr`) and one holds an operand or result (`data`).

An external sequencer drives the block. Each cycle it presents a source code and a load vector, so each cycle performs one register-transfer micro-operation. Every register has its own read-out port, and the live bus value is also an output, so the surrounding logic can watch each transfer.

Top module: `regbus_core`

## Requirements
- R1: A synchronous active-high reset loads gp1=1, gp2=2, gp3=3, instr=0 and data=4.
- R2: `bus_out` combinationally shows the register picked by `src_sel`: 0=gp1, 1=gp2, 2=gp3, 3=instr, 4=data.
- R3: On a rising edge, each register whose `load_vec` bit is set captures `bus_out`. The bit order is bit0=gp1, bit1=gp2, bit2=gp3, bit3=instr, bit4=data.
- R4: A register whose load bit is clear keeps its value, including the register that is the transfer source.
- R5: When the selected source also has its own load bit set, its value does not change.
- R6: Any set of load bits may be set at once, and every loaded register gets the same bus value in that cycle.
- R7: Starting from reset, the transfers gp1→instr, gp1→data, data→gp1 on three consecutive cycles leave instr=1, data=1 and gp1=1.
- R8: Codes 5, 6 and 7 on `src_sel` drive zero on the bus, so any register loaded under such a code becomes 0.
- R9: Reset takes priority over any load request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 3 | Bus source code |
| load_vec | input | 5 | Per-register capture enables |
| bus_out | output | 16 | Current bus value |
| gp1_q | output | 16 | General register 1 |
| gp2_q | output | 16 | General register 2 |
| gp3_q | output | 16 | General register 3 |
| instr_q | output | 16 | Instruction holding register |
| data_q | output | 16 | Operand register |

## Verification
Every register is its own output, so a corrupted register shows up at its port one clock edge after the faulty capture or hold. A wrong source decode shows up on `bus_out` in the same cycle the code is applied. It also spreads to every loaded register at the next edge. The directed transfers therefore compare all five registers after every single step, so a fault is found in the cycle it happens rather than at the end of a sequence.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
   localparam int NUM_REGS = 5;
   localparam int SEL_W    = 3;
   typedef enum logic [SEL_W-1:0] {
      SRC_GP1   = 3'd0,
      SRC_GP2   = 3'd1,
      SRC_GP3   = 3'd2,
      SRC_INSTR = 3'd3,
      SRC_DATA  = 3'd4
   } src_e;
endpackage

// File: rtl/regbus_cell.sv
module regbus_cell #(
   parameter int                DATA_W = 16,
   parameter logic [DATA_W-1:0] INIT   = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= INIT;
      else if (load) q <= d;
   end
endmodule

// File: rtl/regbus_srcmux.sv
module regbus_srcmux #(
   parameter int DATA_W     = 16,
   parameter int NREG       = 5,
   parameter int SEL_W      = 3,
   parameter bit MUX_ONEHOT = 1'b1
) (
   input  logic [DATA_W-1:0] regs_i [NREG],
   input  logic [SEL_W-1:0]  sel,
   output logic [DATA_W-1:0] bus
);
   localparam int SLOTS = 1 << SEL_W;

   generate
      if (MUX_ONEHOT) begin : g_andor
         logic [NREG-1:0] hot;
         always_comb begin
            for (int i = 0; i < NREG; i++) hot[i] = (sel == SEL_W'(i));
         end
         always_comb begin
            bus = '0;
            for (int i = 0; i < NREG; i++) bus = bus | ({DATA_W{hot[i]}} & regs_i[i]);
         end
      end else begin : g_index
         logic [DATA_W-1:0] padded [SLOTS];
         for (genvar j = 0; j < SLOTS; j++) begin : g_pad
            if (j < NREG) begin : g_live
               assign padded[j] = regs_i[j];
            end else begin : g_zero
               assign padded[j] = '0;
            end
         end
         assign bus = padded[sel];
      end
   endgenerate
endmodule

// File: rtl/regbus_core.sv
module regbus_core
   import regbus_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit MUX_ONEHOT = 1'b1,
   parameter int RST_GP1    = 1,
   parameter int RST_GP2    = 2,
   parameter int RST_GP3    = 3,
   parameter int RST_INSTR  = 0,
   parameter int RST_DATA   = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SEL_W-1:0]    src_sel,
   input  logic [NUM_REGS-1:0] load_vec,
   output logic [DATA_W-1:0]   bus_out,
   output logic [DATA_W-1:0]   gp1_q,
   output logic [DATA_W-1:0]   gp2_q,
   output logic [DATA_W-1:0]   gp3_q,
   output logic [DATA_W-1:0]   instr_q,
   output logic [DATA_W-1:0]   data_q
);
   localparam logic [DATA_W-1:0] RST_VEC [NUM_REGS] = '{
      DATA_W'(RST_GP1), DATA_W'(RST_GP2), DATA_W'(RST_GP3),
      DATA_W'(RST_INSTR), DATA_W'(RST_DATA)};

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("regbus_core: DATA_W must be at least 1");
      end
      if ((1 << SEL_W) < NUM_REGS) begin : g_bad_sel
         $error("regbus_core: select code too narrow for register count");
      end
      if (DATA_W < 31) begin : g_rst_range
         if (RST_GP1 >= (1 << DATA_W) || RST_GP2 >= (1 << DATA_W) ||
             RST_GP3 >= (1 << DATA_W) || RST_INSTR >= (1 << DATA_W) ||
             RST_DATA >= (1 << DATA_W)) begin : g_bad_rst
            $error("regbus_core: reset value does not fit DATA_W");
         end
      end
   endgenerate

   logic [DATA_W-1:0] regs_q [NUM_REGS];
   logic [DATA_W-1:0] bus;

   regbus_srcmux #(
      .DATA_W(DATA_W), .NREG(NUM_REGS), .SEL_W(SEL_W), .MUX_ONEHOT(MUX_ONEHOT)
   ) u_srcmux (
      .regs_i(regs_q), .sel(src_sel), .bus(bus)
   );

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         regbus_cell #(.DATA_W(DATA_W), .INIT(RST_VEC[i])) u_cell (
            .clk(clk), .rst(rst), .load(load_vec[i]), .d(bus), .q(regs_q[i])
         );
      end
   endgenerate

   assign bus_out = bus;
   assign gp1_q   = regs_q[SRC_GP1];
   assign gp2_q   = regs_q[SRC_GP2];
   assign gp3_q   = regs_q[SRC_GP3];
   assign instr_q = regs_q[SRC_INSTR];
   assign data_q  = regs_q[SRC_DATA];
endmodule

// File: rtl/regbus_chk.sv
module regbus_chk #(
   parameter int DATA_W    = 16,
   parameter int RST_GP1   = 1,
   parameter int RST_GP2   = 2,
   parameter int RST_GP3   = 3,
   parameter int RST_INSTR = 0,
   parameter int RST_DATA  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        src_sel,
   input logic [4:0]        load_vec,
   input logic [DATA_W-1:0] bus_out,
   input logic [DATA_W-1:0] gp1_q,
   input logic [DATA_W-1:0] gp2_q,
   input logic [DATA_W-1:0] gp3_q,
   input logic [DATA_W-1:0] instr_q,
   input logic [DATA_W-1:0] data_q
);
   localparam logic [DATA_W-1:0] RST_VEC [5] = '{
      DATA_W'(RST_GP1), DATA_W'(RST_GP2), DATA_W'(RST_GP3),
      DATA_W'(RST_INSTR), DATA_W'(RST_DATA)};

   logic [DATA_W-1:0] q_arr [5];
   assign q_arr[0] = gp1_q;
   assign q_arr[1] = gp2_q;
   assign q_arr[2] = gp3_q;
   assign q_arr[3] = instr_q;
   assign q_arr[4] = data_q;

   logic past_valid = 1'b0;
   always_ff @(posedge clk) past_valid <= 1'b1;

   assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (src_sel > 3'd4) |-> (bus_out == '0));

   for (genvar i = 0; i < 5; i++) begin : g_chk
      // R1 and R9: reset values win over any load
      assert_reset_values_R1: assert property (@(posedge clk)
         (past_valid && $past(rst)) |-> (q_arr[i] == RST_VEC[i]));
      assert_bus_source_R2: assert property (@(posedge clk) disable iff (rst)
         (src_sel == 3'(i)) |-> (bus_out == q_arr[i]));
      // R3 and R6: every loaded register takes the previous bus value
      assert_load_capture_R3: assert property (@(posedge clk) disable iff (rst)
         (past_valid && !$past(rst) && $past(load_vec[i])) |-> (q_arr[i] == $past(bus_out)));
      assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
         (past_valid && !$past(rst) && !$past(load_vec[i])) |-> (q_arr[i] == $past(q_arr[i])));
   end
endmodule

bind regbus_core regbus_chk #(
   .DATA_W(DATA_W), .RST_GP1(RST_GP1), .RST_GP2(RST_GP2), .RST_GP3(RST_GP3),
   .RST_INSTR(RST_INSTR), .RST_DATA(RST_DATA)
) u_regbus_chk (
   .clk(clk), .rst(rst), .src_sel(src_sel), .load_vec(load_vec), .bus_out(bus_out),
   .gp1_q(gp1_q), .gp2_q(gp2_q), .gp3_q(gp3_q), .instr_q(instr_q), .data_q(data_q)
);

// File: tb/test_regbus_core.sv
`timescale 1ns/1ps
module test_regbus_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  src_sel = 3'd0;
   logic [4:0]  load_vec = 5'd0;
   logic [15:0] bus_out, gp1_q, gp2_q, gp3_q, instr_q, data_q;

   int n_checks = 0;
   int n_fail   = 0;
   logic [15:0] model [5];

   always #5 clk = ~clk;

   regbus_core i_regbus_core (
      .clk(clk), .rst(rst), .src_sel(src_sel), .load_vec(load_vec), .bus_out(bus_out),
      .gp1_q(gp1_q), .gp2_q(gp2_q), .gp3_q(gp3_q), .instr_q(instr_q), .data_q(data_q)
   );

   task automatic check(input string tag, input string what, input logic [15:0] act,
                        input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      model[0] = 16'd1; model[1] = 16'd2; model[2] = 16'd3;
      model[3] = 16'd0; model[4] = 16'd4;
   endtask

   task automatic check_all(input string tag);
      check(tag, "gp1",   gp1_q,   model[0]);
      check(tag, "gp2",   gp2_q,   model[1]);
      check(tag, "gp3",   gp3_q,   model[2]);
      check(tag, "instr", instr_q, model[3]);
      check(tag, "data",  data_q,  model[4]);
   endtask

   // one transfer: inputs set at a falling edge, exactly one rising edge, then check
   task automatic xfer(input string tag, input logic [2:0] sel, input logic [4:0] ld);
      logic [15:0] b;
      b = (sel < 3'd5) ? model[sel] : 16'd0;
      @(negedge clk);
      src_sel = sel; load_vec = ld;
      #1 check(tag, "bus", bus_out, b);
      @(negedge clk);
      load_vec = 5'd0; src_sel = 3'd0;
      for (int i = 0; i < 5; i++) if (ld[i]) model[i] = b;
      check_all(tag);
   endtask

   task automatic t_reset();
      model_reset();
      check_all("R1");
   endtask

   task automatic t_bus_select();
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         src_sel = 3'(c);
         #1 check((c < 5) ? "R2" : "R8", "bus", bus_out, (c < 5) ? model[c] : 16'd0);
      end
      src_sel = 3'd0;
   endtask

   task automatic t_sequence();
      xfer("R7", 3'd0, 5'b01000);
      xfer("R7", 3'd0, 5'b10000);
      xfer("R7", 3'd4, 5'b00001);
      check("R7", "instr", instr_q, 16'd1);
      check("R7", "data",  data_q,  16'd1);
      check("R7", "gp1",   gp1_q,   16'd1);
   endtask

   task automatic t_single();
      xfer("R3", 3'd2, 5'b00010);
      check("R4", "gp3 source kept", gp3_q, 16'd3);
      xfer("R3", 3'd1, 5'b00100);
      xfer("R4", 3'd3, 5'b00000);
   endtask

   task automatic t_self_load();
      xfer("R5", 3'd1, 5'b00010);
      check("R5", "gp2 self", gp2_q, 16'd3);
   endtask

   task automatic t_multi();
      xfer("R4", 3'd0, 5'b00100);
      xfer("R6", 3'd1, 5'b11001);
      check("R6", "instr", instr_q, 16'd3);
      xfer("R6", 3'd2, 5'b11111);
   endtask

   task automatic t_unused();
      xfer("R8", 3'd6, 5'b00010);
      check("R8", "gp2 cleared", gp2_q, 16'd0);
      xfer("R8", 3'd7, 5'b10100);
   endtask

   task automatic t_reset_priority();
      @(negedge clk);
      rst = 1'b1; src_sel = 3'd6; load_vec = 5'b11111;
      @(negedge clk);
      rst = 1'b0; load_vec = 5'd0; src_sel = 3'd0;
      model_reset();
      check_all("R9");
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_bus_select();
      t_sequence();
      t_single();
      t_self_load();
      t_multi();
      t_unused();
      t_reset_priority();
      t_bus_select();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule